// File: doc/BRIEF.md
# Power-State Sequencer

This block runs the power states of a small system-on-chip. It has three states that software can see: run, nap and deep sleep. In run, the processor clock, the main oscillator and the memory interface all work normally. In nap, only the processor clock is gated. The oscillators and the peripherals keep going, and any enabled interrupt, a key press or the wakeup pin brings the processor back on the next clock edge. Deep sleep also turns off the main oscillator and asks the DRAM controller to hold memory in self-refresh.

Software enters a low-power state by writing to one of two trigger addresses on a simple register bus. The written data has no effect. Deep sleep ends on the wakeup pin, or on a real-time-clock event once the system has left its first power-on standby. On wake, self-refresh is released and the oscillator is enabled first. A programmable number of stabilisation cycles then passes before the processor clock is enabled. Power-on reset places the block in deep sleep.

Top module: `pwr_state_ctrl`

## Requirements
- R1: During and right after reset, state_code is 2'b10, cpu_clk_en is 0, osc_en is 0 and sref_req is 1.
- R2: In run, state_code is 2'b00, cpu_clk_en and osc_en are 1 and sref_req is 0.
- R3: In run, a write (bus_wr=1) to address IDLE_ADDR (default 8'h40) enters nap on that edge, whatever the data. Nap shows state_code 2'b01, cpu_clk_en 0, osc_en 1 and sref_req 0.
- R4: In run, a write to address STBY_ADDR (default 8'h44) enters deep sleep on that edge, whatever the data. Deep sleep shows state_code 2'b10, cpu_clk_en 0, osc_en 0 and sref_req 1.
- R5: A write to any other address, or any write made while not in run, changes no output.
- R6: In nap, the block returns to run on the next edge when any of these holds: some bit i has irq_pending[i]=1 and irq_mask[i]=1 (1 means enabled), key_press=1, or wake_pin=1.
- R7: In nap, interrupts whose mask bit is 0 are ignored.
- R8: In deep sleep, wake_pin=1, or rtc_event=1 when permitted by R10, starts wake-up on that edge. During wake-up, state_code stays 2'b10, osc_en is 1, sref_req is 0 and cpu_clk_en is 0.
- R9: Wake-up lasts exactly warm_cycles+1 cycles. warm_cycles is sampled on the edge that starts the wake-up. The block then enters run.
- R10: After power-on reset, rtc_event does not end deep sleep. Only wake_pin ends that first deep sleep. Later deep sleeps accept either input.
- R11: In deep sleep, interrupts and key presses are ignored.
- R12: cpu_clk_en=1 always implies osc_en=1 and sref_req=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | AW | Register bus address |
| bus_wdata | input | DW | Register bus write data (ignored) |
| irq_pending | input | NIRQ | Pending interrupt flags |
| irq_mask | input | NIRQ | Interrupt enables, 1 = enabled |
| key_press | input | 1 | Keyboard activity |
| wake_pin | input | 1 | External wakeup input |
| rtc_event | input | 1 | Real-time-clock wake event |
| warm_cycles | input | CW | Oscillator stabilisation count |
| cpu_clk_en | output | 1 | Processor clock enable |
| osc_en | output | 1 | Main oscillator enable |
| sref_req | output | 1 | DRAM self-refresh request |
| state_code | output | 2 | 00 run, 01 nap, 10 deep sleep or wake-up |

## Verification
All four outputs are decoded from the state register, so a wrong state shows up as a wrong output on the very next cycle. A wake-up counter that loads or decrements wrongly moves the rising edge of cpu_clk_en. Because the bench uses several different stabilisation counts, even a one-cycle error is caught. If the power-on flag is lost, the first rtc_event leaves deep sleep one edge early, and the bench sees it in that cycle.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
   typedef enum logic [1:0] {
      PS_RUN  = 2'd0,
      PS_NAP  = 2'd1,
      PS_DEEP = 2'd2,
      PS_WARM = 2'd3
   } pstate_t;

   localparam logic [1:0] CODE_RUN  = 2'b00;
   localparam logic [1:0] CODE_NAP  = 2'b01;
   localparam logic [1:0] CODE_DEEP = 2'b10;

   function automatic logic [1:0] code_of(pstate_t s);
      case (s)
         PS_RUN:  code_of = CODE_RUN;
         PS_NAP:  code_of = CODE_NAP;
         default: code_of = CODE_DEEP;
      endcase
   endfunction
endpackage

// File: rtl/pwr_trig_dec.sv
module pwr_trig_dec #(
   parameter int unsigned AW = 8,
   parameter logic [AW-1:0] IDLE_ADDR = '0,
   parameter logic [AW-1:0] STBY_ADDR = '1
) (
   input  logic          wr,
   input  logic [AW-1:0] addr,
   output logic          go_nap,
   output logic          go_deep
);
   // R3 R4: only the address is decoded; the data never reaches here
   assign go_nap  = wr && (addr == IDLE_ADDR);
   assign go_deep = wr && (addr == STBY_ADDR);
endmodule

// File: rtl/pwr_wake_cond.sv
module pwr_wake_cond #(
   parameter int unsigned NIRQ        = 8,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NIRQ-1:0] irq_pending,
   input  logic [NIRQ-1:0] irq_mask,
   input  logic            key_press,
   input  logic            wake_pin,
   input  logic            rtc_event,
   input  logic            cold,
   output logic            nap_exit,
   output logic            deep_exit
);
   logic wake_s, rtc_s;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign wake_s = wake_pin;
         assign rtc_s  = rtc_event;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] wake_q, rtc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wake_q <= '0;
               rtc_q  <= '0;
            end else begin
               for (int i = SYNC_STAGES-1; i > 0; i--) begin
                  wake_q[i] <= wake_q[i-1];
                  rtc_q[i]  <= rtc_q[i-1];
               end
               wake_q[0] <= wake_pin;
               rtc_q[0]  <= rtc_event;
            end
         end
         assign wake_s = wake_q[SYNC_STAGES-1];
         assign rtc_s  = rtc_q[SYNC_STAGES-1];
      end
   endgenerate

   // R6 R7: only enabled interrupts count
   assign nap_exit  = (|(irq_pending & irq_mask)) || key_press || wake_s;
   // R10 R11: interrupts and keys never end deep sleep; rtc only after first wake
   assign deep_exit = wake_s || (rtc_s && !cold);
endmodule

// File: rtl/pwr_warm_timer.sv
module pwr_warm_timer #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          run,
   input  logic [CW-1:0] delay,
   output logic          done
);
   logic [CW-1:0] cnt;

   // R9: loaded on the wake edge, counts down once per wake-up cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (start)              cnt <= delay;
      else if (run && cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign done = run && (cnt == '0);
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
   import pwr_pkg::*;
#(
   parameter int unsigned AW          = 8,
   parameter int unsigned DW          = 32,
   parameter int unsigned NIRQ        = 8,
   parameter int unsigned CW          = 8,
   parameter logic [AW-1:0] IDLE_ADDR = 8'h40,
   parameter logic [AW-1:0] STBY_ADDR = 8'h44,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_wr,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   input  logic [NIRQ-1:0] irq_pending,
   input  logic [NIRQ-1:0] irq_mask,
   input  logic            key_press,
   input  logic            wake_pin,
   input  logic            rtc_event,
   input  logic [CW-1:0]   warm_cycles,
   output logic            cpu_clk_en,
   output logic            osc_en,
   output logic            sref_req,
   output logic [1:0]      state_code
);
   initial begin : p_param_chk
      assert (IDLE_ADDR != STBY_ADDR) else $fatal(1, "trigger addresses collide");
      assert (NIRQ >= 1 && CW >= 1 && AW >= 1) else $fatal(1, "bad widths");
      assert (SYNC_STAGES <= 4) else $fatal(1, "SYNC_STAGES too deep");
   end

   pstate_t st, st_nx;
   logic    cold;
   logic    go_nap, go_deep, nap_exit, deep_exit, warm_start, warm_done;
   logic    unused_wdata;

   assign unused_wdata = ^bus_wdata;

   pwr_trig_dec #(.AW(AW), .IDLE_ADDR(IDLE_ADDR), .STBY_ADDR(STBY_ADDR)) u_dec (
      .wr(bus_wr), .addr(bus_addr), .go_nap(go_nap), .go_deep(go_deep));

   pwr_wake_cond #(.NIRQ(NIRQ), .SYNC_STAGES(SYNC_STAGES)) u_wake (
      .clk(clk), .rst_n(rst_n), .irq_pending(irq_pending), .irq_mask(irq_mask),
      .key_press(key_press), .wake_pin(wake_pin), .rtc_event(rtc_event),
      .cold(cold), .nap_exit(nap_exit), .deep_exit(deep_exit));

   assign warm_start = (st == PS_DEEP) && deep_exit;

   pwr_warm_timer #(.CW(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(warm_start), .run(st == PS_WARM),
      .delay(warm_cycles), .done(warm_done));

   always_comb begin
      st_nx = st;
      case (st)
         PS_RUN:  if (go_nap) st_nx = PS_NAP;           // R3
                  else if (go_deep) st_nx = PS_DEEP;    // R4
         PS_NAP:  if (nap_exit) st_nx = PS_RUN;         // R6
         PS_DEEP: if (deep_exit) st_nx = PS_WARM;       // R8
         PS_WARM: if (warm_done) st_nx = PS_RUN;        // R9
         default: st_nx = PS_DEEP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= PS_DEEP;                               // R1
         cold <= 1'b1;                                  // R10
      end else begin
         st <= st_nx;
         if (warm_start) cold <= 1'b0;
      end
   end

   assign cpu_clk_en = (st == PS_RUN);                  // R2 R12
   assign osc_en     = (st != PS_DEEP);
   assign sref_req   = (st == PS_DEEP);
   assign state_code = code_of(st);
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk #(
   parameter int unsigned AW = 8,
   parameter int unsigned NIRQ = 8,
   parameter int unsigned CW = 8,
   parameter logic [AW-1:0] IDLE_ADDR = 8'h40,
   parameter logic [AW-1:0] STBY_ADDR = 8'h44
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_wr,
   input logic [AW-1:0]   bus_addr,
   input logic [NIRQ-1:0] irq_pending,
   input logic [NIRQ-1:0] irq_mask,
   input logic            key_press,
   input logic            deep_exit,
   input logic [CW-1:0]   warm_cycles,
   input logic            cpu_clk_en,
   input logic            osc_en,
   input logic            sref_req,
   input logic [1:0]      state_code
);
   logic [CW:0]   wcnt;
   logic [CW-1:0] lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt <= '0;
         lat  <= '0;
      end else begin
         if (state_code == 2'b10 && !osc_en) lat <= warm_cycles;
         if (state_code == 2'b10 && osc_en) wcnt <= wcnt + 1'b1;
         else wcnt <= '0;
      end
   end

   AST_CLK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clk_en |-> (osc_en && !sref_req)); // R12
   AST_NAP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'b00 && bus_wr && bus_addr == IDLE_ADDR) |=> (state_code == 2'b01 && !cpu_clk_en)); // R3
   AST_DEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'b00 && bus_wr && bus_addr == STBY_ADDR) |=> (state_code == 2'b10 && sref_req && !osc_en)); // R4
   AST_NAP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'b01 && ((|(irq_pending & irq_mask)) || key_press)) |=> (state_code == 2'b00)); // R6
   AST_DEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'b10 && !osc_en && !deep_exit) |=> (state_code == 2'b10 && !osc_en)); // R11
   AST_WARM_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 2'b10 && !sref_req) |-> (osc_en && !cpu_clk_en)); // R8
   AST_WARM_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cpu_clk_en) && $past(state_code) == 2'b10) |-> (wcnt == ({1'b0, lat} + 1'b1))); // R9
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk #(
   .AW(AW), .NIRQ(NIRQ), .CW(CW), .IDLE_ADDR(IDLE_ADDR), .STBY_ADDR(STBY_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .irq_pending(irq_pending), .irq_mask(irq_mask), .key_press(key_press),
   .deep_exit(deep_exit), .warm_cycles(warm_cycles), .cpu_clk_en(cpu_clk_en),
   .osc_en(osc_en), .sref_req(sref_req), .state_code(state_code));

// File: tb/sim_pwr_state_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_state_ctrl;
   localparam logic [7:0] A_NAP  = 8'h40;
   localparam logic [7:0] A_DEEP = 8'h44;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [7:0]  irq_pending = '0, irq_mask = '0;
   logic        key_press = 1'b0, wake_pin = 1'b0, rtc_event = 1'b0;
   logic [7:0]  warm_cycles = '0;
   logic        cpu_clk_en, osc_en, sref_req;
   logic [1:0]  state_code;

   int checks = 0, errors = 0;
   int m_st = 2, m_cnt = 0;
   bit m_cold = 1'b1;

   always #10 clk = ~clk;

   pwr_state_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .irq_pending(irq_pending), .irq_mask(irq_mask),
      .key_press(key_press), .wake_pin(wake_pin), .rtc_event(rtc_event),
      .warm_cycles(warm_cycles), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
      .sref_req(sref_req), .state_code(state_code));

   function automatic logic [4:0] exp_outs(int s);
      // {code, cpu, osc, sref}
      case (s)
         0: exp_outs = {2'b00, 1'b1, 1'b1, 1'b0};
         1: exp_outs = {2'b01, 1'b0, 1'b1, 1'b0};
         2: exp_outs = {2'b10, 1'b0, 1'b0, 1'b1};
         default: exp_outs = {2'b10, 1'b0, 1'b1, 1'b0};
      endcase
   endfunction

   task automatic model_edge();
      case (m_st)
         0: if (bus_wr && bus_addr == A_NAP) m_st = 1;
            else if (bus_wr && bus_addr == A_DEEP) m_st = 2;
         1: if ((|(irq_pending & irq_mask)) || key_press || wake_pin) m_st = 0;
         2: if (wake_pin || (rtc_event && !m_cold)) begin
               m_st = 3; m_cnt = warm_cycles; m_cold = 1'b0;
            end
         default: if (m_cnt == 0) m_st = 0; else m_cnt--;
      endcase
   endtask

   task automatic compare(string tag);
      logic [4:0] act, exp;
      act = {state_code, cpu_clk_en, osc_en, sref_req};
      exp = exp_outs(m_st);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b (code,cpu,osc,sref)", tag, act, exp);
      end
   endtask

   task automatic cyc(bit wr, logic [7:0] a, logic [7:0] irq, logic [7:0] msk,
                      bit key, bit wk, bit rtc, logic [7:0] dly, string tag);
      bus_wr = wr; bus_addr = a; bus_wdata = $urandom;
      irq_pending = irq; irq_mask = msk; key_press = key;
      wake_pin = wk; rtc_event = rtc; warm_cycles = dly;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare(tag);
   endtask

   function automatic string tag_of(int s);
      case (s)
         0: tag_of = "R2";
         1: tag_of = "R3";
         2: tag_of = "R4";
         default: tag_of = "R9";
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      compare("R1 during reset");
      rst_n = 1'b1;
      cyc(0, 0, 0, 0, 0, 0, 0, 0, "R1 after reset");
      cyc(0, 0, 0, 0, 0, 0, 1, 2, "R10 rtc after POR ignored");
      cyc(0, 0, 8'hFF, 8'hFF, 1, 0, 0, 2, "R11 irq/key in deep");
      cyc(0, 0, 0, 0, 0, 1, 0, 3, "R8 wake pin starts warm-up");
      cyc(0, 0, 0, 0, 0, 0, 0, 9, "R9 warm 1");
      cyc(0, 0, 0, 0, 0, 0, 0, 9, "R9 warm 2");
      cyc(0, 0, 0, 0, 0, 0, 0, 9, "R9 warm 3");
      cyc(0, 0, 0, 0, 0, 0, 0, 9, "R9 run after 4 cycles");
      cyc(1, 8'h41, 0, 0, 0, 0, 0, 0, "R5 other address");
      cyc(1, A_NAP, 0, 0, 0, 0, 0, 0, "R3 nap entry");
      cyc(1, A_DEEP, 0, 0, 0, 0, 0, 0, "R5 write in nap");
      cyc(0, 0, 8'h01, 8'hFE, 0, 0, 0, 0, "R7 masked irq");
      cyc(0, 0, 8'h01, 8'h01, 0, 0, 0, 0, "R6 enabled irq");
      cyc(1, A_DEEP, 0, 0, 0, 0, 0, 0, "R4 deep entry");
      cyc(0, 0, 0, 0, 0, 0, 1, 0, "R8 rtc wake after first");
      cyc(0, 0, 0, 0, 0, 0, 0, 0, "R9 zero delay run");
      cyc(1, A_NAP, 0, 0, 0, 0, 0, 0, "R3 nap again");
      cyc(0, 0, 0, 0, 1, 0, 0, 0, "R6 key press");
      cyc(1, A_NAP, 0, 0, 0, 0, 0, 0, "R3 nap third");
      cyc(0, 0, 0, 0, 0, 1, 0, 0, "R6 wake pin in nap");
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] a;
         int r = $urandom_range(0, 3);
         a = (r == 0) ? A_NAP : (r == 1) ? A_DEEP : 8'($urandom);
         cyc($urandom_range(0, 3) == 0, a, 8'($urandom), 8'($urandom & $urandom),
             $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0,
             $urandom_range(0, 7) == 0, 8'($urandom_range(0, 7)),
             (i % 2 == 0) ? tag_of(m_st) : "R12 output relation");
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule